// File: doc/BRIEF.md
# Dual-Pipeline Group Issue Unit

This block sits between the decode stage and two execution pipelines. Decode hands over a fetch group of decoded operations, at most four by default. The block then sends those operations out in program order. It uses two pipes. The full pipe accepts every operation class. The lite pipe accepts only simple ALU operations.

Each cycle the unit looks at the two oldest operations that have not yet issued. It decides in hardware whether both may leave together. A pair is refused for any of these reasons:
- the younger operation reads a register that the older one writes;
- both operations write the same nonzero register;
- both operations are complex;
- the lite pipe is stalled.

When a pair is refused, the oldest operation goes alone to the full pipe. A new group is taken only after every operation of the current group has issued.

Each operation record is 24 bits wide. Its fields are a tag, a complex flag, a destination register and two source registers. The unit passes the whole record, unchanged, to the pipe that receives it.

Top module: `group_issue_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `grp_ready` is 1 and neither `a_valid` nor `b_valid` is asserted.
- R2: `grp_ready` is 1 exactly when no operation of the current group remains. A group is taken on a clock edge where `grp_valid` and `grp_ready` are both 1, and its first issue can happen in the following cycle. While a group remains, `grp_ops` and `grp_count` have no effect. `grp_count` (1 to GROUP_MAX) selects how many lanes are used. Lane k sits at bits [24k+23:24k] and lane 0 is the oldest. Lanes at or above `grp_count` are never issued.
- R3: Whenever anything issues, the oldest remaining operation issues. When two issue together, they are the two oldest remaining, so order is never broken.
- R4: No pair issues when the older operation's destination is nonzero and equals either source of the younger operation.
- R5: No pair issues when both operations write the same destination, unless that destination is register 0.
- R6: No pair issues when both operations have the complex flag set.
- R7: Record layout: tag [23:16], complex flag [15], destination [14:10], source A [9:5], source B [4:0]. A complex operation always leaves on the full pipe (`a_op`), and `b_op` never carries a complex operation. When a simple older operation pairs with a complex younger one, the younger goes on `a_op` and the older on `b_op`.
- R8: While `a_stall` is 1, nothing issues on either pipe and the position in the group is held.
- R9: While `b_stall` is 1, no pair issues. The oldest operation still issues alone on the full pipe if `a_stall` is 0.
- R10: When two operations remain and none of the refusals in R4, R5, R6 or R9 applies, both issue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | A fetch group is offered |
| grp_ready | output | 1 | Unit can take a group (nothing remains) |
| grp_count | input | 3 | Number of used lanes in the offered group |
| grp_ops | input | 96 | Packed operation records, lane 0 oldest |
| a_stall | input | 1 | Full pipe cannot accept this cycle |
| a_valid | output | 1 | An operation issues to the full pipe this cycle |
| a_op | output | 24 | Record issued to the full pipe |
| b_stall | input | 1 | Lite pipe cannot accept this cycle |
| b_valid | output | 1 | An operation issues to the lite pipe this cycle |
| b_op | output | 24 | Record issued to the lite pipe |

## Verification
Several properties are checked on every cycle by assertions:
- the lite pipe never receives a complex record;
- two issued records never share a nonzero destination;
- a stall on either pipe suppresses the issues it must suppress;
- a stalled group keeps its position;
- an accepted group is not empty in the next cycle.

Some behaviours can only be shown by the bench's scenarios, which compare against an independent model of the rules. These are:
- that the oldest operations are the ones chosen;
- that a read-after-write pair is refused;
- that a legal pair really pairs;
- that the issue order is kept and complex operations are swapped onto the full pipe;
- that offers made while a group is draining are ignored.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

    localparam int REG_W = 5;
    localparam int TAG_W = 8;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             cplx;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
    } op_t;

    localparam int OP_W = $bits(op_t);

    // true when register r is a real (writable) register that y reads
    function automatic logic reads_live(logic [REG_W-1:0] r,
                                        logic [REG_W-1:0] sa,
                                        logic [REG_W-1:0] sb);
        return (r != '0) && ((sa == r) || (sb == r));
    endfunction

endpackage

// File: rtl/group_buffer.sv
module group_buffer
    import dual_issue_pkg::*;
#(
    parameter int GROUP_MAX = 4,
    localparam int CNT_W = $clog2(GROUP_MAX + 1),
    localparam int IDX_W = (GROUP_MAX > 1) ? $clog2(GROUP_MAX) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [CNT_W-1:0]          in_count,
    input  logic [GROUP_MAX*OP_W-1:0] in_data,
    output logic                      in_ready,
    input  logic [1:0]                advance,
    output op_t                       older,
    output op_t                       younger,
    output logic [CNT_W-1:0]          rem
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_MAX - 1);
    localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(GROUP_MAX);

    op_t              slot [GROUP_MAX];
    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] nxt_idx;
    logic [CNT_W-1:0] cnt_eff;
    logic             load;

    assign in_ready = (rem == '0);
    assign load     = in_valid && in_ready;
    assign cnt_eff  = (in_count > MAX_CNT) ? MAX_CNT : in_count;
    assign nxt_idx  = (pos == LAST_IDX) ? '0 : pos + IDX_W'(1);
    assign older    = slot[pos];
    assign younger  = slot[nxt_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
            pos <= '0;
        end else if (load) begin
            rem <= cnt_eff;
            pos <= '0;
        end else if (advance != 2'd0) begin
            rem <= rem - CNT_W'(advance);
            pos <= pos + IDX_W'(advance);
        end
    end

    for (genvar k = 0; k < GROUP_MAX; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (load) begin
                slot[k] <= op_t'(in_data[k*OP_W +: OP_W]);
            end
        end
    end

    AST_ADVANCE_BOUND: assert property (@(posedge clk) disable iff (rst)
        CNT_W'(advance) <= rem); // R3

    AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_count != '0) |=> (rem != '0)); // R2

    AST_HOLD_POS: assert property (@(posedge clk) disable iff (rst)
        (rem != '0 && advance == 2'd0) |=> ($stable(pos) && $stable(rem))); // R8

endmodule

// File: rtl/pair_check.sv
module pair_check
    import dual_issue_pkg::*;
(
    input  logic             o_cplx,
    input  logic [REG_W-1:0] o_dst,
    input  logic             y_cplx,
    input  logic [REG_W-1:0] y_dst,
    input  logic [REG_W-1:0] y_sa,
    input  logic [REG_W-1:0] y_sb,
    input  logic             y_present,
    input  logic             lite_free,
    output logic             pair,
    output logic             swap
);

    logic raw_hit;
    logic waw_hit;
    logic cls_hit;

    always_comb begin
        raw_hit = reads_live(o_dst, y_sa, y_sb);
        waw_hit = (o_dst != '0) && (o_dst == y_dst);
        cls_hit = o_cplx && y_cplx;
        pair    = y_present && lite_free && !raw_hit && !waw_hit && !cls_hit;
        swap    = pair && !o_cplx && y_cplx;
    end

endmodule

// File: rtl/issue_steer.sv
module issue_steer
    import dual_issue_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] rem,
    input  logic             a_stall,
    input  logic             pair,
    input  logic             swap,
    input  op_t              older,
    input  op_t              younger,
    output logic             a_go,
    output logic             b_go,
    output op_t              a_rec,
    output op_t              b_rec,
    output logic [1:0]       advance
);

    always_comb begin
        a_go    = (rem != '0) && !a_stall;
        b_go    = a_go && pair;
        a_rec   = swap ? younger : older;
        b_rec   = swap ? older : younger;
        advance = !a_go ? 2'd0 : (b_go ? 2'd2 : 2'd1);
    end

endmodule

// File: rtl/group_issue_unit.sv
module group_issue_unit
    import dual_issue_pkg::*;
#(
    parameter int GROUP_MAX = 4,
    localparam int CNT_W = $clog2(GROUP_MAX + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      grp_valid,
    output logic                      grp_ready,
    input  logic [CNT_W-1:0]          grp_count,
    input  logic [GROUP_MAX*OP_W-1:0] grp_ops,
    input  logic                      a_stall,
    output logic                      a_valid,
    output logic [OP_W-1:0]           a_op,
    input  logic                      b_stall,
    output logic                      b_valid,
    output logic [OP_W-1:0]           b_op
);

    op_t              older;
    op_t              younger;
    op_t              a_rec;
    op_t              b_rec;
    logic [CNT_W-1:0] rem;
    logic [1:0]       advance;
    logic             pair;
    logic             swap;

    group_buffer #(.GROUP_MAX(GROUP_MAX)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .in_valid (grp_valid),
        .in_count (grp_count),
        .in_data  (grp_ops),
        .in_ready (grp_ready),
        .advance  (advance),
        .older    (older),
        .younger  (younger),
        .rem      (rem)
    );

    pair_check u_pair (
        .o_cplx    (older.cplx),
        .o_dst     (older.dst),
        .y_cplx    (younger.cplx),
        .y_dst     (younger.dst),
        .y_sa      (younger.src_a),
        .y_sb      (younger.src_b),
        .y_present (rem >= CNT_W'(2)),
        .lite_free (!b_stall),
        .pair      (pair),
        .swap      (swap)
    );

    issue_steer #(.CNT_W(CNT_W)) u_steer (
        .rem     (rem),
        .a_stall (a_stall),
        .pair    (pair),
        .swap    (swap),
        .older   (older),
        .younger (younger),
        .a_go    (a_valid),
        .b_go    (b_valid),
        .a_rec   (a_rec),
        .b_rec   (b_rec),
        .advance (advance)
    );

    assign a_op = a_rec;
    assign b_op = b_rec;

    AST_LITE_SIMPLE: assert property (@(posedge clk) disable iff (rst)
        b_valid |-> !b_op[OP_W-TAG_W-1]); // R7

    AST_NO_SHARED_DST: assert property (@(posedge clk) disable iff (rst)
        (b_valid && a_rec.dst != '0) |-> (a_rec.dst != b_rec.dst)); // R5

    AST_FULL_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        a_stall |-> (!a_valid && !b_valid)); // R8

    AST_LITE_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        b_stall |-> !b_valid); // R9

    AST_LITE_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        b_valid |-> a_valid); // R3

endmodule

// File: tb/group_issue_unit_test.sv
`timescale 1ns/100ps
module group_issue_unit_test;

    localparam int GM = 4;
    localparam int OW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          grp_valid = 1'b0;
    logic          grp_ready;
    logic [2:0]    grp_count = 3'd0;
    logic [GM*OW-1:0] grp_ops = '0;
    logic          a_stall = 1'b0;
    logic          a_valid;
    logic [OW-1:0] a_op;
    logic          b_stall = 1'b0;
    logic          b_valid;
    logic [OW-1:0] b_op;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] seed = 32'h1234_5679;
    logic [7:0]  tag_ctr = 8'd0;

    logic [OW-1:0] m_g [GM];
    int m_rem = 0;
    int m_pos = 0;
    int groups_done = 0;

    always #2.5 clk = ~clk;

    group_issue_unit uut (
        .clk(clk), .rst(rst),
        .grp_valid(grp_valid), .grp_ready(grp_ready),
        .grp_count(grp_count), .grp_ops(grp_ops),
        .a_stall(a_stall), .a_valid(a_valid), .a_op(a_op),
        .b_stall(b_stall), .b_valid(b_valid), .b_op(b_op)
    );

    function logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // why a pair is refused: 0 paired (R10), 1 single left (R3), 2 lite stall (R9),
    // 3 both complex (R6), 4 read-after-write (R4), 5 same destination (R5)
    function automatic int pair_reason(logic [OW-1:0] o, logic [OW-1:0] y,
                                       bit have_y, bit bs);
        if (!have_y) return 1;
        if (bs) return 2;
        if (o[15] && y[15]) return 3;
        if (o[14:10] != 5'd0 && (y[9:5] == o[14:10] || y[4:0] == o[14:10])) return 4;
        if (o[14:10] != 5'd0 && o[14:10] == y[14:10]) return 5;
        return 0;
    endfunction

    function automatic string why_req(int why);
        case (why)
            0: return "R10";
            1: return "R3";
            2: return "R9";
            3: return "R6";
            4: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic cycle_step();
        logic [31:0] r;
        logic [31:0] r2;
        logic [OW-1:0] o;
        logic [OW-1:0] y;
        logic [OW-1:0] ea_op;
        logic [OW-1:0] eb_op;
        bit ea, eb, sw, acc;
        int why, c, adv;
        @(negedge clk);
        r = rnd();
        a_stall   = (r[1:0] == 2'd0);
        b_stall   = (r[3:2] == 2'd0);
        grp_valid = (r[6:4] != 3'd0);
        c = 2 + (int'(r[9:8]) % 3);
        grp_count = 3'(c);
        for (int k = 0; k < GM; k++) begin
            r2 = rnd();
            tag_ctr = tag_ctr + 8'd1;
            grp_ops[k*OW +: OW] = {tag_ctr, r2[0], 3'b000, r2[2:1],
                                   3'b000, r2[4:3], 3'b000, r2[6:5]};
        end
        #1;
        o = m_g[m_pos % GM];
        y = (m_pos + 1 < GM) ? m_g[m_pos + 1] : '0;
        why = pair_reason(o, y, m_rem >= 2, b_stall);
        ea = (m_rem > 0) && !a_stall;
        eb = ea && (why == 0);
        sw = eb && !o[15] && y[15];
        ea_op = sw ? y : o;
        eb_op = sw ? o : y;

        chk(grp_ready == (m_rem == 0), "R2", "grp_ready", 32'(grp_ready), 32'(m_rem == 0));
        chk(a_valid == ea, a_stall ? "R8" : "R3", "a_valid", 32'(a_valid), 32'(ea));
        if (ea && a_valid)
            chk(a_op == ea_op, sw ? "R7" : "R3", "a_op", 32'(a_op), 32'(ea_op));
        chk(b_valid == eb, a_stall ? "R8" : why_req(why), "b_valid", 32'(b_valid), 32'(eb));
        if (eb && b_valid)
            chk(b_op == eb_op, "R7", "b_op", 32'(b_op), 32'(eb_op));

        acc = (m_rem == 0) && grp_valid;
        if (ea) begin
            adv = eb ? 2 : 1;
            m_pos += adv;
            m_rem -= adv;
        end
        if (acc) begin
            for (int k = 0; k < GM; k++) m_g[k] = grp_ops[k*OW +: OW];
            m_pos = 0;
            m_rem = c;
            groups_done++;
        end
    endtask

    initial begin : main
        fork
            begin
                for (int k = 0; k < GM; k++) m_g[k] = '0;
                repeat (3) @(negedge clk);
                #1;
                chk(grp_ready == 1'b1, "R1", "ready in reset", 32'(grp_ready), 32'd1);
                chk(a_valid == 1'b0 && b_valid == 1'b0, "R1", "valids in reset",
                    {30'd0, a_valid, b_valid}, 32'd0);
                @(negedge clk);
                rst = 1'b0;
                #1;
                chk(grp_ready == 1'b1, "R1", "ready after reset", 32'(grp_ready), 32'd1);
                chk(a_valid == 1'b0 && b_valid == 1'b0, "R1", "valids after reset",
                    {30'd0, a_valid, b_valid}, 32'd0);
                while (groups_done < 800) cycle_step();
                // drain the last group
                while (m_rem > 0) cycle_step();
            end
            begin
                repeat (150000) @(posedge clk);
                n_fail++;
                $display("FAIL R2 watchdog actual=hung expected=finished");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule